// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects eight hardware request lines and drives one interrupt output towards a processor. It keeps a pending-request register, an in-service register and a mask register, each one bit per line. Line 0 has the highest priority and line 7 the lowest. The output is raised only when an unmasked pending line outranks everything currently in service.

Software reaches the block through a byte-wide port with one address-select input. The command location (select low) takes commands and returns either the request or the in-service register. The data location (select high) reads and writes the mask. A configuration command also picks edge or level triggering and arms a one-shot load of the vector base. The acknowledge input returns a vector built from that base and the winning line number. On the next edge it moves the winner from pending to in-service. A non-specific end-of-interrupt command retires the highest-priority in-service bit.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are 0, triggering is edge mode, the vector base is 0, the command location reads back the request register, and int_o is low.
- R2: In edge mode a request bit sets on a 0-to-1 change of its line and holds until acknowledged. A line that stays high does not set the bit again; it must first be seen low.
- R3: In level mode each request bit follows its line on every clock edge. The bit of an acknowledged line is cleared on the acknowledge edge and then follows the line again.
- R4: A write at the data location (sel_i=1) with no base load armed loads wdata_i into the mask. A read at the data location returns the mask.
- R5: A command write (sel_i=0) with bit 3 set selects the readback from bit 0: 0 selects the request register and 1 selects the in-service register. The command location then returns the selected register.
- R6: A command write with bit 3 clear and bit 5 set clears the lowest-numbered set bit of the in-service register.
- R7: A command write with bits 3 and 5 clear and bit 4 set sets level mode when bit 2 is 1 and edge mode when bit 2 is 0. It also arms a base load: the next data-location write loads the base from wdata_i[7:3] instead of the mask, and later data writes go to the mask again.
- R8: int_o is high exactly when some line is pending, unmasked, and numbered lower than every in-service bit. A mask bit on one line does not block any other line.
- R9: While ack_i is high and int_o is high, rdata_o is {base, n}, where n is the lowest-numbered line that qualifies under R8. On that edge request bit n clears and in-service bit n sets.
- R10: While ack_i is high and int_o is low, rdata_o is {base, 3'b111}, and neither the request nor the in-service register changes.
- R11: A command write with bits 3, 4 and 5 all clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Request lines, bit n is line n |
| sel_i | input | 1 | Address select: 0 command location, 1 data location |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| ack_i | input | 1 | Interrupt acknowledge |
| rdata_o | output | 8 | Read data: vector while ack_i is high, otherwise the addressed location |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
A change on a request line shows in the request register, and so on int_o, one clock edge later. A register write, an end-of-interrupt or an acknowledge likewise shows its effect one edge after the cycle that carries it. The acknowledge vector and the readback mux are combinational, so they are due in the same cycle as ack_i or sel_i. The bench drives inputs a quarter period after each rising edge. It updates a behavioural model on the same rising edge the design uses, and compares int_o and rdata_o with the model at every falling edge. Directed checks with literal values are taken at the same point in the cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned N_LINES = 8;
  localparam int unsigned DATA_W  = 8;

  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;

  // command byte fields
  localparam int unsigned CMD_RSEL_BIT = 3;
  localparam int unsigned CMD_CFG_BIT  = 4;
  localparam int unsigned CMD_EOI_BIT  = 5;
  localparam int unsigned CFG_LVL_BIT  = 2;
  localparam int unsigned RSEL_ISR_BIT = 0;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_pkg::*;
#(
  parameter int unsigned N = N_LINES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  trig_e        mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] req_q, irr_d;

  always_comb begin
    if (mode_i == TRIG_LEVEL) irr_d = req_i;
    else                      irr_d = irr_o | (req_i & ~req_q);
    irr_d = irr_d & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      irr_o <= '0;
    end else begin
      req_q <= req_i;
      irr_o <= irr_d;
    end
  end

  // R2
  edge_new_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_EDGE) |=> ((irr_o & ~$past(irr_o) & ~($past(req_i) & ~$past(req_q))) == '0));

  // R3
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_LEVEL) |=> ((irr_o & ~$past(req_i)) == '0));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  isr_i,
  input  logic [N-1:0]  mask_i,
  output logic          hit_o,
  output logic [LW-1:0] win_o
);
  logic [N-1:0] below_isr, cand;

  // lines numbered below the lowest in-service bit; all lines when none in service
  assign below_isr = (isr_i & (~isr_i + 1'b1)) - 1'b1;
  assign cand      = irr_i & ~mask_i & below_isr;
  assign hit_o     = |cand;

  always_comb begin
    win_o = LW'(N - 1);
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) win_o = LW'(i);
    end
  end
endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import irq_pkg::*;
#(
  parameter int unsigned N  = N_LINES,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = DW - $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N-1:0]  mask_o,
  output logic [BW-1:0] base_o,
  output trig_e         mode_o,
  output logic          rsel_isr_o,
  output logic          eoi_o
);
  logic cmd_wr, base_arm_q;

  assign cmd_wr = wr_i & ~sel_i;
  assign eoi_o  = cmd_wr & ~wdata_i[CMD_RSEL_BIT] & wdata_i[CMD_EOI_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= '0;
      base_o     <= '0;
      mode_o     <= TRIG_EDGE;
      rsel_isr_o <= 1'b0;
      base_arm_q <= 1'b0;
    end else if (wr_i && sel_i) begin
      if (base_arm_q) begin
        base_o     <= wdata_i[DW-1 -: BW];
        base_arm_q <= 1'b0;
      end else begin
        mask_o <= wdata_i[N-1:0];
      end
    end else if (cmd_wr) begin
      if (wdata_i[CMD_RSEL_BIT]) begin
        rsel_isr_o <= wdata_i[RSEL_ISR_BIT];
      end else if (!wdata_i[CMD_EOI_BIT] && wdata_i[CMD_CFG_BIT]) begin
        mode_o     <= wdata_i[CFG_LVL_BIT] ? TRIG_LEVEL : TRIG_EDGE;
        base_arm_q <= 1'b1;
      end
    end
  end

  // R4
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && !base_arm_q) |=> (mask_o == $past(wdata_i[N-1:0])));

  // R7
  base_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && base_arm_q) |=> (base_o == $past(wdata_i[DW-1 -: BW])) && $stable(mask_o));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N  = N_LINES,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned LW = $clog2(N),
  localparam int unsigned BW = DW - LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  output logic [DW-1:0] rdata_o,
  output logic          int_o
);
  logic [N-1:0]  irr_q, isr_q, isr_d, mask_q, clr;
  logic [BW-1:0] base_q;
  logic [LW-1:0] win;
  logic          hit, grant, eoi, rsel_isr;
  trig_e         mode_q;

  assign grant = ack_i & hit;
  assign clr   = grant ? (N'(1) << win) : '0;
  assign int_o = hit;

  irq_bus_regs #(.N(N), .DW(DW), .BW(BW)) u_regs (
    .clk_i, .rst_ni, .sel_i, .wr_i, .wdata_i,
    .mask_o(mask_q), .base_o(base_q), .mode_o(mode_q),
    .rsel_isr_o(rsel_isr), .eoi_o(eoi)
  );

  irq_req_latch #(.N(N)) u_req (
    .clk_i, .rst_ni, .req_i(irq_i), .mode_i(mode_q), .clr_i(clr), .irr_o(irr_q)
  );

  irq_prio #(.N(N), .LW(LW)) u_prio (
    .irr_i(irr_q), .isr_i(isr_q), .mask_i(mask_q), .hit_o(hit), .win_o(win)
  );

  always_comb begin
    isr_d = isr_q;
    if (eoi) isr_d = isr_d & ~(isr_d & (~isr_d + 1'b1));
    isr_d = isr_d | clr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  always_comb begin
    if (ack_i)       rdata_o = {base_q, win};
    else if (sel_i)  rdata_o = DW'(mask_q);
    else if (rsel_isr) rdata_o = DW'(isr_q);
    else             rdata_o = DW'(irr_q);
  end

  // R8
  int_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr_q & ~mask_q) != '0));

  // R9
  ack_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && !eoi) |=> isr_q[$past(win)] && ($countones(isr_q) == $countones($past(isr_q)) + 1));

  // R10
  spurious_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o && !eoi) |=> $stable(isr_q));

  // R6
  eoi_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && !ack_i && isr_q != '0) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       sel = 1'b0, wr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       intr;

  int total = 0, bad = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .sel_i(sel), .wr_i(wr),
    .wdata_i(wdata), .ack_i(ack), .rdata_o(rdata), .int_o(intr)
  );

  // behavioural reference
  bit m_irr[8], m_isr[8], m_mask[8], m_prev[8];
  int m_base;
  bit m_lvl, m_rsel, m_arm;

  function automatic int m_winner();
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) return -1;
      if (m_irr[i] && !m_mask[i]) return i;
    end
    return -1;
  endfunction

  function automatic int pack(bit a[8]);
    int v = 0;
    for (int i = 0; i < 8; i++) if (a[i]) v += (1 << i);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_irr[i] = 0; m_isr[i] = 0; m_mask[i] = 0; m_prev[i] = 0;
      end
      m_base = 0; m_lvl = 0; m_rsel = 0; m_arm = 0;
    end else begin
      automatic int w = m_winner();
      for (int i = 0; i < 8; i++) begin
        if (m_lvl) m_irr[i] = irq[i];
        else if (irq[i] && !m_prev[i]) m_irr[i] = 1;
        m_prev[i] = irq[i];
      end
      if (ack && w >= 0) begin
        m_irr[w] = 0;
        m_isr[w] = 1;
      end
      if (wr && sel) begin
        if (m_arm) begin m_base = wdata / 8; m_arm = 0; end
        else for (int i = 0; i < 8; i++) m_mask[i] = wdata[i];
      end else if (wr) begin
        if (wdata[3]) m_rsel = wdata[0];
        else if (wdata[5]) begin
          for (int i = 0; i < 8; i++) if (m_isr[i]) begin m_isr[i] = 0; break; end
        end else if (wdata[4]) begin m_lvl = wdata[2]; m_arm = 1; end
      end
    end
  end

  task automatic check(string t, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int w = m_winner();
      automatic int exp_rd;
      if (ack)      exp_rd = m_base * 8 + (w >= 0 ? w : 7);
      else if (sel) exp_rd = pack(m_mask);
      else if (m_rsel) exp_rd = pack(m_isr);
      else          exp_rd = pack(m_irr);
      check({tag, " int_o"}, int'(intr), int'(w >= 0));
      check({tag, " rdata_o"}, int'(rdata), exp_rd);
    end
  end

  task automatic go(int n);
    repeat (n) begin @(posedge clk); #QTR; end
  endtask

  task automatic bus_wr(bit s, logic [7:0] d);
    sel = s; wr = 1'b1; wdata = d;
    go(1);
    wr = 1'b0; sel = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; go(1); ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    go(2);
    #1 rst_n = 1'b1;
    go(1);
    tag = "R1";
    check("R1 int_o", int'(intr), 0);
    check("R1 request readback", int'(rdata), 0);
    sel = 1'b1; #1;
    check("R1 mask readback", int'(rdata), 0);
    sel = 1'b0;

    tag = "R7"; // edge mode, base load armed, base = 8
    bus_wr(1'b0, 8'h10);
    bus_wr(1'b1, 8'h40);
    tag = "R4";
    bus_wr(1'b1, 8'h00);
    sel = 1'b1; go(1); sel = 1'b0;

    tag = "R2";
    irq[3] = 1'b1; go(2);
    check("R2 int_o after rise", int'(intr), 1);
    tag = "R9";
    ack = 1'b1; #1;
    check("R9 vector line 3", int'(rdata), 8'h43);
    go(1); ack = 1'b0;
    tag = "R5";
    bus_wr(1'b0, 8'h09); go(1);
    check("R5 isr readback", int'(rdata), 8'h08);

    tag = "R8"; // lower-priority line blocked by in-service line 3
    irq[5] = 1'b1; go(2);
    check("R8 line 5 blocked", int'(intr), 0);
    irq[1] = 1'b1; go(2);
    check("R8 line 1 preempts", int'(intr), 1);
    pulse_ack(); go(1);
    tag = "R6";
    bus_wr(1'b0, 8'h20); go(1);
    check("R6 eoi retires line 1", int'(rdata), 8'h08);
    bus_wr(1'b0, 8'h20); go(1);
    tag = "R8";
    check("R8 line 5 after eoi", int'(intr), 1);

    tag = "R11";
    bus_wr(1'b0, 8'h00); go(1);
    check("R11 no change", int'(rdata), 8'h00);

    tag = "R8"; // mask line 5, raise line 6 below it
    bus_wr(1'b1, 8'h20);
    irq[6] = 1'b1; go(2);
    check("R8 mask skips to 6", int'(intr), 1);
    ack = 1'b1; #1;
    check("R9 vector line 6", int'(rdata), 8'h46);
    go(1); ack = 1'b0;
    bus_wr(1'b0, 8'h20);

    tag = "R2"; // held high: no relatch
    bus_wr(1'b1, 8'h00);
    bus_wr(1'b0, 8'h08); go(1);
    pulse_ack(); bus_wr(1'b0, 8'h20); go(2);
    check("R2 held line no relatch", int'(intr), 0);
    irq[5] = 1'b0; go(2); irq[5] = 1'b1; go(2);
    check("R2 relatch after low", int'(intr), 1);
    pulse_ack(); bus_wr(1'b0, 8'h20);

    tag = "R10";
    irq = '0; go(2);
    ack = 1'b1; #1;
    check("R10 spurious vector", int'(rdata), 8'h47);
    go(1); ack = 1'b0; go(1);

    tag = "R3"; // level mode, base 2
    bus_wr(1'b0, 8'h14);
    bus_wr(1'b1, 8'h10);
    irq[4] = 1'b1; go(2);
    check("R3 level pending", int'(intr), 1);
    irq[4] = 1'b0; go(2);
    check("R3 level drop clears", int'(intr), 0);
    irq[2] = 1'b1; go(2);
    ack = 1'b1; #1;
    check("R9 level vector", int'(rdata), 8'h12);
    go(1); ack = 1'b0; go(3);
    bus_wr(1'b0, 8'h20); go(2);
    check("R3 level reasserts", int'(intr), 1);
    irq = '0; go(3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule